// File: doc/BRIEF.md
# Parallel Port Control Register

This block is the host-writable control register of a PC-style parallel port. A single byte written by the host sets four printer control lines, an interrupt enable and a data direction bit. Some bits reach their pins inverted and others do not. The direction bit only takes effect when the port runs in one of its bidirectional modes; in plain printer mode the data bus is always driven outward.

The acknowledge input from the printer is brought into the clock domain through two flops. A rising transition on it, seen while the interrupt enable is set, raises a level interrupt. That interrupt stays high until the host signals a status read or turns the enable off.

Top module: `lpt_ctrl_reg`

## Requirements
- R1: After reset the register holds zero, so strobe_n=1, autofd_n=1, init_n=0, selin_n=1, irq=0 and dir_in=0.
- R2: A cycle with host_wr=1 stores host_wdata[5:0] at that clock edge. While host_rd=1, host_rdata is {2'b00, stored bits 5..0}. While host_rd=0, host_rdata is 0.
- R3: Bit 0 drives strobe_n inverted. Bit 1 drives autofd_n inverted. Bit 2 drives init_n without inversion. Bit 3 drives selin_n inverted, so writing 1 to bit 3 selects the printer.
- R4: Bits 7 and 6 always read back as 0, and writing 1 to them changes no output.
- R5: port_mode is encoded as 0 printer, 1 bidirectional, 2 EPP and 3 ECP. In modes 1 to 3, dir_in equals bit 5 (1 means input). In mode 0, dir_in is 0 whatever bit 5 holds.
- R6: With bit 4 (interrupt enable) set, a 0-to-1 change on ack_n raises irq at the third rising clock edge after the change, and not before.
- R7: While bit 4 is 0, irq is 0. An ack_n rising edge seen while bit 4 is 0 is not remembered, and a write that clears bit 4 drops irq at the same edge.
- R8: Once raised, irq stays 1 until a cycle with status_rd=1. A falling ack_n has no effect on irq.
- R9: If a new ack_n rising edge is detected in the same cycle as status_rd=1, irq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, enables host_rdata |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, 0 when not reading |
| port_mode | input | 2 | 0 printer, 1 bidirectional, 2 EPP, 3 ECP |
| ack_n | input | 1 | Acknowledge pin from the printer, asynchronous |
| status_rd | input | 1 | Pulse when the host reads the status register |
| strobe_n | output | 1 | Strobe pin |
| autofd_n | output | 1 | Auto line feed pin |
| init_n | output | 1 | Initialise pin |
| selin_n | output | 1 | Printer select pin |
| irq | output | 1 | Interrupt request, level |
| dir_in | output | 1 | 1 turns the data bus to input |

## Verification
The hardest case to reach is an acknowledge edge that leaves the synchronizer in the very cycle the host reads status. The pending interrupt has to be cleared and a new one set in the same cycle. The bench first raises irq, then drives a fresh ack_n rise and counts two clock edges. It asserts status_rd across the third edge, where the detected edge is captured, and expects irq to remain high. Separate cases cover an edge while the enable is off, followed by enabling it, to prove the edge was not stored.

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg #(
  parameter logic [7:0] WR_MASK = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [1:0] port_mode,
  input  logic       ack_n,
  input  logic       status_rd,
  output logic       strobe_n,
  output logic       autofd_n,
  output logic       init_n,
  output logic       selin_n,
  output logic       irq,
  output logic       dir_in
);

  localparam logic [1:0] MODE_PRINTER = 2'd0;

  logic [7:0] ctl;
  logic       ack_s1, ack_s2, ack_d;
  logic       ack_rise;
  logic       ien_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl <= 8'h00;
    else if (host_wr) ctl <= host_wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b1;
      ack_s2 <= 1'b1;
      ack_d  <= 1'b1;
    end else begin
      ack_s1 <= ack_n;
      ack_s2 <= ack_s1;
      ack_d  <= ack_s2;
    end
  end

  assign ack_rise = ack_s2 & ~ack_d;
  assign ien_nxt  = host_wr ? host_wdata[4] : ctl[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ien_nxt & (ack_rise | (irq & ~status_rd));
  end

  assign strobe_n   = ~ctl[0];
  assign autofd_n   = ~ctl[1];
  assign init_n     =  ctl[2];
  assign selin_n    = ~ctl[3];
  assign dir_in     = (port_mode != MODE_PRINTER) & ctl[5];
  assign host_rdata = host_rd ? ctl : 8'h00;

  // R2: a write lands in the register at its edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ctl == ($past(host_wdata) & WR_MASK));

  // R7: a disabled interrupt never shows
  a_r7_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[4] |-> !irq);

  // R6: irq only rises from a synchronized acknowledge edge
  a_r6_rise_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_rise));

  // R8: a status read without a new edge clears the request
  a_r8_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_rd) && !$past(ack_rise)) |-> !irq);

endmodule

// File: tb/test_lpt_ctrl_reg.sv
module test_lpt_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, status_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [1:0] port_mode = 2'd0;
  logic       ack_n = 1'b1;
  logic       strobe_n, autofd_n, init_n, selin_n, irq, dir_in;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpt_ctrl_reg i_lpt_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .port_mode(port_mode),
    .ack_n(ack_n), .status_rd(status_rd), .strobe_n(strobe_n),
    .autofd_n(autofd_n), .init_n(init_n), .selin_n(selin_n),
    .irq(irq), .dir_in(dir_in)
  );

  // {mode, wdata, {strobe_n, autofd_n, init_n, selin_n, dir_in}}
  localparam logic [14:0] VEC [11] = '{
    {2'd0, 8'h01, 5'b01010},
    {2'd1, 8'h02, 5'b10010},
    {2'd0, 8'h04, 5'b11110},
    {2'd2, 8'h08, 5'b11000},
    {2'd0, 8'h20, 5'b11010},
    {2'd1, 8'h20, 5'b11011},
    {2'd2, 8'h20, 5'b11011},
    {2'd3, 8'h20, 5'b11011},
    {2'd3, 8'hFF, 5'b00101},
    {2'd0, 8'hC0, 5'b11010},
    {2'd1, 8'h2F, 5'b00101}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clocks(3);
    // R1: reset state
    check("R1 pins", {3'b0, strobe_n, autofd_n, init_n, selin_n, dir_in}, 8'b00011010);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    clocks(1);
    host_rd = 1'b1; #1;
    check("R1 read zero", host_rdata, 8'h00);
    host_rd = 1'b0;

    // R2 R3 R4 R5: vector table
    foreach (VEC[i]) begin
      port_mode = VEC[i][14:13];
      wr(VEC[i][12:5]);
      #1;
      check("R3 R5 pins", {3'b0, strobe_n, autofd_n, init_n, selin_n, dir_in},
            {3'b0, VEC[i][4:0]});
      host_rd = 1'b1; #1;
      check("R2 R4 readback", host_rdata, {2'b00, VEC[i][10:5]});
      host_rd = 1'b0; #1;
      check("R2 idle read", host_rdata, 8'h00);
    end

    // R6: latency of the acknowledge edge
    port_mode = 2'd1;
    wr(8'h10);
    ack_n = 1'b0; clocks(4);
    ack_n = 1'b1;
    clocks(2);
    check("R6 not before third edge", {7'b0, irq}, 8'h00);
    clocks(1);
    check("R6 raised", {7'b0, irq}, 8'h01);

    // R8: falling ack does nothing, stays until status read
    ack_n = 1'b0; clocks(5);
    check("R8 held", {7'b0, irq}, 8'h01);
    status_rd = 1'b1; clocks(1); status_rd = 1'b0;
    check("R8 cleared by status", {7'b0, irq}, 8'h00);

    // R7: clearing enable drops irq at the write edge
    ack_n = 1'b1; clocks(4);
    check("R7 setup raised", {7'b0, irq}, 8'h01);
    wr(8'h00);
    check("R7 dropped on disable", {7'b0, irq}, 8'h00);

    // R7: edge while disabled is not remembered
    ack_n = 1'b0; clocks(4);
    ack_n = 1'b1; clocks(5);
    wr(8'h10); clocks(3);
    check("R7 edge not stored", {7'b0, irq}, 8'h00);

    // R9: new edge coincides with status read
    ack_n = 1'b0; clocks(4);
    ack_n = 1'b1; clocks(4);
    check("R9 setup raised", {7'b0, irq}, 8'h01);
    ack_n = 1'b0; clocks(4);
    ack_n = 1'b1;
    clocks(2);
    status_rd = 1'b1; clocks(1); status_rd = 1'b0;
    check("R9 set wins", {7'b0, irq}, 8'h01);

    // R5: printer mode overrides the stored direction bit
    wr(8'h20);
    port_mode = 2'd2; #1;
    check("R5 epp input", {7'b0, dir_in}, 8'h01);
    port_mode = 2'd0; #1;
    check("R5 printer forces output", {7'b0, dir_in}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule